// File: doc/BRIEF.md
# Prioritised 32-Line Interrupt Controller

This block collects 32 interrupt request lines and steers them onto two parent request outputs: a normal-class output and a fast-class output. Each line has its own configuration word. The word holds a 5-bit priority, a choice between edge sensing and level sensing, and a routing bit that selects the class. Pending lines that are not masked compete in a priority resolver, one resolver for each class.

Each class has a two-state arbitration machine. The states are ARMED and HELD.

- Transition ARM_TO_HELD happens when the class is armed and at least one eligible line exists. On this transition the index of the winning line is latched and the class output is raised.
- Transition HELD_TO_ARM happens when software writes the acknowledge bit for that class in the control word. This lowers the output.
- A held class stays in HELD until that acknowledge arrives.

Firmware services a request by reading the class index register. When the winning line is edge-sensed, that read also clears the line's pending bit. Firmware then acknowledges the class so that the next winner can be presented. A software-set register lets firmware raise a line as if its input had become active.

Inputs are synchronous and active-high. The register port is a simple 32-bit read/write port with byte addresses. Read data is registered.

Top module: `intc_top`

## Requirements
- R1: After reset the mask register (offset 0x04) reads all ones, the pending register (0x00) and every line configuration word read zero, both classes are armed, and both outputs are low.
- R2: The configuration word of line n lives at offset 0x1C + 4·n. Bits [6:2] hold the priority, bit 1 selects level sensing (0 = edge, 1 = level), and bit 0 routes the line to the fast class. Writes store these bits and ignore all others. Reads return them with zeros above.
- R3: An edge-sensed line becomes pending only when its input goes from inactive to active. A line whose input stays active does not pend again after its pending bit has been cleared.
- R4: A level-sensed line is pending in every cycle its input is active. Its pending bit clears when the input goes inactive.
- R5: A write to the pending register ANDs the written value into the pending bits. The clear is ignored for a level-sensed line whose input is active at that time.
- R6: A line whose mask bit is 1 never takes part in arbitration and cannot raise either output.
- R7: Among eligible lines of one class, the lowest priority value wins. On equal priority the higher line number wins. A line takes part only in the class chosen by its routing bit.
- R8: A class output rises, and that class's index is latched, only when the class is armed and an eligible line exists. The output then stays high until the class is acknowledged. Control bit 0 (offset 0x18) acknowledges the normal class, and control bit 1 acknowledges the fast class. An acknowledge lowers the output in the next cycle. Reads of the control word return zero.
- R9: The normal index (0x10) and the fast index (0x14) read back the latched winning line number. If that line is edge-sensed, the read clears its pending bit. If it is level-sensed, the read leaves the bit alone. Writes to either index register are ignored.
- R10: A write to the software-set register (0x9C) makes only the lowest set bit of the written value pending.
- R11: Reads of undefined offsets, and of 0x9C, return zero. Writes to undefined offsets change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_i | input | 32 | Interrupt request inputs, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq_norm_o | output | 1 | Normal-class parent request |
| irq_fast_o | output | 1 | Fast-class parent request |

## Verification
A register write, an input change or a software-set updates the pending bits at the next clock edge. A read in the following cycle sees that update, and a class output rises one edge after the pending bit appears. An acknowledge lowers the output at the edge that captures the write, and an eligible line re-raises it one edge later.

Read results are registered, so the scoreboard pairs each expected value with the read issued in the cycle before. Output checks are timed in whole clock edges counted from the stimulus. Every sample is taken at a falling edge.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int unsigned NLINES = 32;
    localparam int unsigned PRI_W  = 5;
    localparam int unsigned DW     = 32;
    localparam int unsigned AW     = 8;
    localparam int unsigned IDX_W  = $clog2(NLINES);

    localparam logic [AW-1:0] OFF_PEND  = 8'h00;
    localparam logic [AW-1:0] OFF_MASK  = 8'h04;
    localparam logic [AW-1:0] OFF_IDX_N = 8'h10;
    localparam logic [AW-1:0] OFF_IDX_F = 8'h14;
    localparam logic [AW-1:0] OFF_CTRL  = 8'h18;
    localparam logic [AW-1:0] OFF_CFG0  = 8'h1C;
    localparam logic [AW-1:0] OFF_SWSET = 8'h9C;

    typedef enum logic [0:0] {
        ARB_ARMED = 1'b0,
        ARB_HELD  = 1'b1
    } arb_state_e;
endpackage

// File: rtl/intc_resolver.sv
module intc_resolver #(
    parameter int unsigned N  = 32,
    parameter int unsigned PW = 5,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]         elig_i,
    input  logic [N-1:0][PW-1:0] pri_i,
    output logic                 found_o,
    output logic [IW-1:0]        win_o
);
    logic [PW-1:0] best;

    // Ascending scan with <= lets a later (higher) line win a tie.
    always_comb begin
        found_o = 1'b0;
        best    = '0;
        win_o   = '0;
        for (int i = 0; i < int'(N); i++) begin
            if (elig_i[i] && (!found_o || pri_i[i] <= best)) begin
                found_o = 1'b1;
                best    = pri_i[i];
                win_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/intc_arb_fsm.sv
module intc_arb_fsm
    import intc_pkg::*;
#(
    parameter int unsigned IW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ack_i,
    input  logic          found_i,
    input  logic [IW-1:0] win_i,
    output logic          irq_o,
    output logic [IW-1:0] idx_o
);
    arb_state_e state_q, state_d;
    logic [IW-1:0] idx_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_ARMED: if (!ack_i && found_i) state_d = ARB_HELD;  // ARM_TO_HELD
            ARB_HELD:  if (ack_i)             state_d = ARB_ARMED; // HELD_TO_ARM
            default:   state_d = ARB_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_ARMED;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ARB_ARMED && state_d == ARB_HELD)
                idx_q <= win_i;
        end
    end

    always_comb begin
        irq_o = (state_q == ARB_HELD);
        idx_o = idx_q;
    end
endmodule

// File: rtl/intc_pending.sv
module intc_pending #(
    parameter int unsigned N  = 32,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  line_i,
    input  logic [N-1:0]  level_i,
    input  logic          and_en_i,
    input  logic [N-1:0]  and_val_i,
    input  logic          rdclr_en_i,
    input  logic [IW-1:0] rdclr_idx_i,
    input  logic          swset_en_i,
    input  logic [N-1:0]  swset_hot_i,
    output logic [N-1:0]  pend_o
);
    logic [N-1:0] in_q, pend_q, pend_d;

    for (genvar g = 0; g < int'(N); g++) begin : g_line
        logic keep, set, rise, fall;
        always_comb begin
            rise = line_i[g] & ~in_q[g];
            fall = ~line_i[g] & in_q[g];
            keep = pend_q[g];
            if (and_en_i)
                keep = keep & (and_val_i[g] | (line_i[g] & level_i[g]));
            if (rdclr_en_i && rdclr_idx_i == IW'(g) && !level_i[g])
                keep = 1'b0;
            if (level_i[g] && fall)
                keep = 1'b0;
            set = (level_i[g] ? line_i[g] : rise) | (swset_en_i & swset_hot_i[g]);
            pend_d[g] = keep | set;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q   <= '0;
            pend_q <= '0;
        end else begin
            in_q   <= line_i;
            pend_q <= pend_d;
        end
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/intc_top.sv
module intc_top
    import intc_pkg::*;
#(
    parameter int unsigned N_LINES = NLINES,
    parameter int unsigned PW      = PRI_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] line_i,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [AW-1:0]      bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    output logic               irq_norm_o,
    output logic               irq_fast_o
);
    localparam int unsigned IW = $clog2(N_LINES);
    localparam logic [AW-1:0] CFG_LAST = AW'(OFF_CFG0 + 4 * (N_LINES - 1));

    logic [N_LINES-1:0]         mask_q, lvl_q, fast_q, pend;
    logic [N_LINES-1:0][PW-1:0] pri_q;
    logic [DW-1:0]              rdata_q, rd_val;
    logic                       cfg_hit;
    logic [IW-1:0]              cfg_line;
    logic [1:0]                 ack, found, irq;
    logic [1:0][IW-1:0]         win, idx;
    logic [1:0][N_LINES-1:0]    elig;
    logic                       rdclr_en;
    logic [IW-1:0]              rdclr_idx;

    assign cfg_hit  = (bus_addr >= OFF_CFG0) && (bus_addr <= CFG_LAST) && (bus_addr[1:0] == 2'b00);
    assign cfg_line = IW'((bus_addr - OFF_CFG0) >> 2);

    assign ack[0] = bus_wr && bus_addr == OFF_CTRL && bus_wdata[0];
    assign ack[1] = bus_wr && bus_addr == OFF_CTRL && bus_wdata[1];

    assign rdclr_en  = bus_rd && (bus_addr == OFF_IDX_N || bus_addr == OFF_IDX_F);
    assign rdclr_idx = (bus_addr == OFF_IDX_N) ? idx[0] : idx[1];

    // configuration and mask storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
            lvl_q  <= '0;
            fast_q <= '0;
            pri_q  <= '0;
        end else if (bus_wr) begin
            if (bus_addr == OFF_MASK)
                mask_q <= bus_wdata[N_LINES-1:0];
            if (cfg_hit) begin
                pri_q[cfg_line]  <= bus_wdata[PW+1:2];
                lvl_q[cfg_line]  <= bus_wdata[1];
                fast_q[cfg_line] <= bus_wdata[0];
            end
        end
    end

    intc_pending #(.N(N_LINES), .IW(IW)) u_pend (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_i      (line_i),
        .level_i     (lvl_q),
        .and_en_i    (bus_wr && bus_addr == OFF_PEND),
        .and_val_i   (bus_wdata[N_LINES-1:0]),
        .rdclr_en_i  (rdclr_en),
        .rdclr_idx_i (rdclr_idx),
        .swset_en_i  (bus_wr && bus_addr == OFF_SWSET),
        .swset_hot_i (bus_wdata[N_LINES-1:0] & (~bus_wdata[N_LINES-1:0] + 1'b1)),
        .pend_o      (pend)
    );

    for (genvar c = 0; c < 2; c++) begin : g_cls
        if (c == 0) begin : g_norm
            assign elig[c] = pend & ~mask_q & ~fast_q;
        end else begin : g_fast
            assign elig[c] = pend & ~mask_q & fast_q;
        end

        intc_resolver #(.N(N_LINES), .PW(PW), .IW(IW)) u_res (
            .elig_i  (elig[c]),
            .pri_i   (pri_q),
            .found_o (found[c]),
            .win_o   (win[c])
        );

        intc_arb_fsm #(.IW(IW)) u_arb (
            .clk     (clk),
            .rst_n   (rst_n),
            .ack_i   (ack[c]),
            .found_i (found[c]),
            .win_i   (win[c]),
            .irq_o   (irq[c]),
            .idx_o   (idx[c])
        );
    end

    // read path
    always_comb begin
        rd_val = '0;
        if (bus_addr == OFF_PEND)       rd_val = DW'(pend);
        else if (bus_addr == OFF_MASK)  rd_val = DW'(mask_q);
        else if (bus_addr == OFF_IDX_N) rd_val = DW'(idx[0]);
        else if (bus_addr == OFF_IDX_F) rd_val = DW'(idx[1]);
        else if (cfg_hit)               rd_val = DW'({pri_q[cfg_line], lvl_q[cfg_line], fast_q[cfg_line]});
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_val;
    end

    assign bus_rdata  = rdata_q;
    assign irq_norm_o = irq[0];
    assign irq_fast_o = irq[1];
endmodule

// File: rtl/intc_sva.sv
module intc_sva #(
    parameter int unsigned IW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic [7:0]    bus_addr,
    input logic [31:0]   bus_wdata,
    input logic          irq_norm_o,
    input logic          irq_fast_o,
    input logic [1:0]    found,
    input logic [IW-1:0] idx_n,
    input logic [IW-1:0] idx_f
);
    logic ack_n, ack_f;
    assign ack_n = bus_wr && bus_addr == 8'h18 && bus_wdata[0];
    assign ack_f = bus_wr && bus_addr == 8'h18 && bus_wdata[1];

    assert_ack_drops_norm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_n |=> !irq_norm_o);
    assert_ack_drops_fast_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_f |=> !irq_fast_o);
    assert_hold_norm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_norm_o && !ack_n) |=> irq_norm_o);
    assert_hold_fast_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_fast_o && !ack_f) |=> irq_fast_o);
    assert_rise_needs_winner_norm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_norm_o) |-> $past(found[0]));
    assert_rise_needs_winner_fast_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_fast_o) |-> $past(found[1]));
    assert_index_stable_norm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_norm_o && $past(irq_norm_o)) |-> $stable(idx_n));
    assert_index_stable_fast_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_fast_o && $past(irq_fast_o)) |-> $stable(idx_f));
endmodule

bind intc_top intc_sva u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .irq_norm_o (irq_norm_o),
    .irq_fast_o (irq_fast_o),
    .found      (found),
    .idx_n      (idx[0]),
    .idx_f      (idx[1])
);

// File: tb/intc_top_tb_top.sv
`timescale 1ns/1ps
module intc_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] line_i = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_norm_o, irq_fast_o;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    typedef struct { logic [31:0] exp; string tag; } sb_item_t;
    sb_item_t sb[$];
    logic rd_q = 1'b0;

    always #2.5 clk = ~clk;

    intc_top dut_i (
        .clk(clk), .rst_n(rst_n), .line_i(line_i),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_norm_o(irq_norm_o), .irq_fast_o(irq_fast_o)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: read data arrives one edge after the strobe
    always @(posedge clk) rd_q <= bus_rd;
    always @(negedge clk) begin
        if (rd_q) begin
            sb_item_t it;
            if (sb.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL scoreboard empty actual=%h expected=none", bus_rdata);
            end else begin
                it = sb.pop_front();
                check(it.tag, bus_rdata, it.exp);
            end
        end
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
        sb_item_t it;
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        it.exp = exp; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_all();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_all();
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        check("R1 irq_norm", {31'b0, irq_norm_o}, 0);
        check("R1 irq_fast", {31'b0, irq_fast_o}, 0);
        rd(8'h04, 32'hFFFF_FFFF, "R1 mask");
        rd(8'h00, 32'h0, "R1 pending");
        rd(8'h30, 32'h0, "R1 cfg5");

        // R2 configuration fields
        wr(8'h28, 32'h1F);
        rd(8'h28, 32'h1F, "R2 cfg3");
        wr(8'h98, 32'h7C);
        rd(8'h98, 32'h7C, "R2 cfg31");
        wr(8'h2C, 32'hFFFF_FFFF);
        rd(8'h2C, 32'h7F, "R2 cfg4 upper ignored");
        wr(8'h28, 0); wr(8'h98, 0); wr(8'h2C, 0);

        // R3 edge pending, no re-pend while held high
        line_i[2] = 1'b1;
        rd(8'h00, 32'h4, "R3 edge pend");
        wr(8'h00, 32'hFFFF_FFFB);
        rd(8'h00, 32'h0, "R3 no re-pend");
        line_i[2] = 1'b0;

        // R4 / R5 level line
        wr(8'h34, 32'h2);
        line_i[6] = 1'b1;
        rd(8'h00, 32'h40, "R4 level pend");
        wr(8'h00, 32'h0);
        rd(8'h00, 32'h40, "R5 clear ignored level active");
        line_i[6] = 1'b0;
        rd(8'h00, 32'h0, "R4 level clears on inactive");
        line_i[1] = 1'b1; line_i[2] = 1'b1;
        rd(8'h00, 32'h6, "R5 two edges");
        wr(8'h00, 32'hFFFF_FFFD);
        rd(8'h00, 32'h4, "R5 and write");
        wr(8'h00, 32'h0);
        rd(8'h00, 32'h0, "R5 clear all");
        line_i[1] = 1'b0; line_i[2] = 1'b0;

        // R6 mask / R8 / R9
        line_i[9] = 1'b1;
        tick(2);
        check("R6 masked no irq", {31'b0, irq_norm_o}, 0);
        wr(8'h04, 32'hFFFF_FDFF);
        tick(1);
        check("R8 irq rises", {31'b0, irq_norm_o}, 1);
        rd(8'h10, 32'd9, "R9 index");
        rd(8'h00, 32'h0, "R9 edge cleared by read");
        check("R8 held until ack", {31'b0, irq_norm_o}, 1);
        wr(8'h18, 32'h1);
        check("R8 ack drops", {31'b0, irq_norm_o}, 0);
        tick(2);
        check("R8 stays low when empty", {31'b0, irq_norm_o}, 0);
        rd(8'h18, 32'h0, "R8 control reads zero");
        line_i[9] = 1'b0;

        // R7 priority order
        wr(8'h04, 32'h0);
        wr(8'h44, 32'd3 << 2);
        wr(8'h4C, 32'd1 << 2);
        wr(8'h58, 32'd1 << 2);
        line_i[10] = 1'b1; line_i[12] = 1'b1; line_i[15] = 1'b1;
        tick(2);
        check("R7 irq", {31'b0, irq_norm_o}, 1);
        rd(8'h10, 32'd15, "R7 tie higher line wins");
        wr(8'h18, 32'h1);
        check("R8 ack low", {31'b0, irq_norm_o}, 0);
        tick(1);
        check("R8 rearm raises", {31'b0, irq_norm_o}, 1);
        rd(8'h10, 32'd12, "R7 next pri1");
        wr(8'h18, 32'h1);
        tick(1);
        rd(8'h10, 32'd10, "R7 pri3 last");
        wr(8'h18, 32'h1);
        tick(1);
        check("R7 all served", {31'b0, irq_norm_o}, 0);
        line_i[10] = 1'b0; line_i[12] = 1'b0; line_i[15] = 1'b0;

        // R7 fast routing, R8 per-class ack
        wr(8'h6C, 32'h1);
        line_i[20] = 1'b1;
        tick(2);
        check("R7 fast irq", {31'b0, irq_fast_o}, 1);
        check("R7 normal idle", {31'b0, irq_norm_o}, 0);
        rd(8'h14, 32'd20, "R9 fast index");
        wr(8'h18, 32'h1);
        check("R8 normal ack keeps fast", {31'b0, irq_fast_o}, 1);
        wr(8'h18, 32'h2);
        check("R8 fast ack", {31'b0, irq_fast_o}, 0);
        line_i[20] = 1'b0;

        // R9 level line not cleared by index read; index writes ignored
        wr(8'h38, 32'hA);
        line_i[7] = 1'b1;
        tick(2);
        check("R9 level irq", {31'b0, irq_norm_o}, 1);
        rd(8'h10, 32'd7, "R9 level index");
        rd(8'h00, 32'h80, "R9 level kept");
        wr(8'h18, 32'h1);
        tick(1);
        check("R8 level re-raise", {31'b0, irq_norm_o}, 1);
        line_i[7] = 1'b0;
        tick(1);
        wr(8'h18, 32'h1);
        tick(1);
        check("R4 level gone no irq", {31'b0, irq_norm_o}, 0);
        wr(8'h10, 32'h1F);
        rd(8'h10, 32'd7, "R9 index write ignored");

        // R10 software set lowest bit
        wr(8'h9C, 32'h0003_0000);
        rd(8'h00, 32'h0001_0000, "R10 lowest bit only");
        rd(8'h10, 32'd16, "R10 index");
        wr(8'h18, 32'h1);
        rd(8'h00, 32'h0, "R10 cleared");

        // R11 undefined offsets
        rd(8'h08, 32'h0, "R11 undefined");
        rd(8'h9C, 32'h0, "R11 swset reads zero");
        rd(8'hA0, 32'h0, "R11 beyond map");
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h04, 32'h0, "R11 write no effect");

        tick(3);
        finish_all();
    end
endmodule